// File: doc/BRIEF.md
# DCC Track Signal Packet Receiver

This block turns a digital model-railway track signal into received packets. It counts ticks of a 1 MHz time base between consecutive transitions of the track signal. Each interval is sorted as a one-half, a zero-half or noise. Matching half pairs become bits. A frame tracker then hunts for the preamble, catches the packet start bit, gathers data bytes most significant bit first, and reads the separator bit after each byte.

When the end bit arrives, the block raises a single-cycle pulse. At that moment the received bytes and their count are already final. That pulse can launch a track cutout sequencer. Two faults raise a single-cycle error pulse instead and send the block back to preamble hunting: a half pair that does not match, and a packet that grows too long. The block does not check the checksum, filter addresses or interpret commands.

Top module: `dcc_rx_top`

## Requirements
- R1: While reset is held and right after it is released, `byteCount` is 0, `rxBytes` is all zero, and neither pulse output is high.
- R2: An interval is the number of `tick` pulses between two consecutive transitions of `trackIn`. An interval from ONE_MIN to ONE_MAX inclusive (default 52..64) is a one-half. An interval from ZERO_MIN to ZERO_MAX inclusive (default 90..10000) is a zero-half.
- R3: An interval in neither window is ignored and changes no state. A packet that has such intervals inserted between its halves still decodes to the same bytes.
- R4: A bit is taken only from two consecutive halves of the same class. A one-half followed by a zero-half, or the reverse, raises `frameError` for one cycle and returns the block to preamble search. The next well-formed packet decodes normally.
- R5: Preamble search needs more than 10 consecutive one bits. A zero bit restarts the run, so a packet with only 10 preamble ones, or with its ones split by a zero, gives no `packetValid`.
- R6: After a valid preamble, the first zero bit is the packet start bit. It sets `byteCount` to 0, clears `rxBytes`, and restarts byte assembly.
- R7: Each byte is 8 bits shifted in MSB first. Byte k of the packet lands in `rxBytes[8k+7:8k]`, and `byteCount` rises by one after each completed byte.
- R8: After each byte comes a separator bit. A 0 means another byte follows. A 1 is the end bit: `packetValid` pulses for one cycle while `byteCount` holds the final count, and the block returns to preamble search.
- R9: If a byte completes while `byteCount` already equals MAX_BYTES (default 6), `frameError` pulses, no `packetValid` follows, and the block returns to preamble search. A packet of exactly MAX_BYTES bytes is accepted.
- R10: `packetValid` and `frameError` are never high in the same cycle. Each lasts one cycle. `byteCount` never exceeds MAX_BYTES and only steps up by one or drops to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse from the 1 MHz time base |
| trackIn | input | 1 | Track signal, already synchronized to `clk` |
| rxBytes | output | MAX_BYTES*8 | Received bytes; byte k in bits 8k+7..8k |
| byteCount | output | $clog2(MAX_BYTES+1) | Number of bytes completed in the current packet |
| packetValid | output | 1 | One-cycle pulse on the packet end bit |
| frameError | output | 1 | One-cycle pulse on half mismatch or oversize abort |

## Verification
The assertions assume that `trackIn` is glitch-free and synchronous to `clk`. They also assume that `tick` is a single-cycle pulse and that consecutive transitions are separated by many clock cycles, so the two pulse outputs can never fire in back-to-back cycles. The bench keeps within these limits: it spaces tick pulses two clocks apart and toggles `trackIn` only on a falling clock edge, right after the last counted tick. That makes every measured interval exactly the number of ticks the bench issued. This exact timing lets the window edges (52, 64, 65, 90) be tested without any off-by-one slack.

// File: rtl/dcc_rx_pkg.sv
package dcc_rx_pkg;

  // Half-bit pairing state
  typedef enum logic [1:0] {
    HALF_ANY  = 2'd0,
    HALF_ONE  = 2'd1,
    HALF_ZERO = 2'd2
  } halfState_t;

  // Frame tracking state
  typedef enum logic [1:0] {
    FR_PREAMBLE = 2'd0,
    FR_START    = 2'd1,
    FR_DATA     = 2'd2,
    FR_SEP      = 2'd3
  } frameState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearAll;    // start bit: wipe buffer, counters
    logic shiftIn;     // shift a data bit into the byte register
    logic commitByte;  // eighth bit: store assembled byte
    logic bitVal;      // value of the accepted bit
  } dpCtrl_t;

endpackage

// File: rtl/dcc_rx_datapath.sv
module dcc_rx_datapath
  import dcc_rx_pkg::*;
#(
  parameter int TIMER_W   = 16,
  parameter int ONE_MIN   = 52,
  parameter int ONE_MAX   = 64,
  parameter int ZERO_MIN  = 90,
  parameter int ZERO_MAX  = 10000,
  parameter int MAX_BYTES = 6,
  parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   trackIn,
  input  dpCtrl_t                ctrl,
  output logic                   halfOne,
  output logic                   halfZero,
  output logic                   lastBit,
  output logic                   atMax,
  output logic [MAX_BYTES*8-1:0] rxBytes,
  output logic [CNT_W-1:0]       byteCount
);

  localparam logic [TIMER_W-1:0] ONE_LO  = TIMER_W'(ONE_MIN);
  localparam logic [TIMER_W-1:0] ONE_HI  = TIMER_W'(ONE_MAX);
  localparam logic [TIMER_W-1:0] ZERO_LO = TIMER_W'(ZERO_MIN);
  localparam logic [TIMER_W-1:0] ZERO_HI = TIMER_W'(ZERO_MAX);
  localparam logic [CNT_W-1:0]   CNT_MAX = CNT_W'(MAX_BYTES);

  logic               prevTrack;
  logic               edgeSeen;
  logic [TIMER_W-1:0] interval;
  logic [2:0]         bitCnt;
  logic [7:0]         shiftReg;
  logic [7:0]         nextByte;

  assign edgeSeen = trackIn ^ prevTrack;
  assign nextByte = {shiftReg[6:0], ctrl.bitVal};

  // Interval timer: ticks since the last transition, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevTrack <= 1'b0;
      interval  <= '0;
    end else begin
      prevTrack <= trackIn;
      if (edgeSeen)
        interval <= '0;
      else if (tick && (interval != '1))
        interval <= interval + 1'b1;
    end
  end

  // Half-bit classification on each transition
  assign halfOne  = edgeSeen && (interval >= ONE_LO)  && (interval <= ONE_HI);
  assign halfZero = edgeSeen && (interval >= ZERO_LO) && (interval <= ZERO_HI);

  // Byte assembly
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteCount <= '0;
    end else if (ctrl.clearAll) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteCount <= '0;
    end else if (ctrl.commitByte) begin
      bitCnt    <= '0;
      shiftReg  <= '0;
      byteCount <= byteCount + 1'b1;
    end else if (ctrl.shiftIn) begin
      bitCnt    <= bitCnt + 1'b1;
      shiftReg  <= nextByte;
    end
  end

  assign lastBit = (bitCnt == 3'd7);
  assign atMax   = (byteCount == CNT_MAX);

  // Packet buffer, one register per byte slot
  for (genvar i = 0; i < MAX_BYTES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || ctrl.clearAll)
        rxBytes[8*i +: 8] <= '0;
      else if (ctrl.commitByte && (byteCount == CNT_W'(i)))
        rxBytes[8*i +: 8] <= nextByte;
    end
  end

endmodule

// File: rtl/dcc_rx_control.sv
module dcc_rx_control
  import dcc_rx_pkg::*;
#(
  parameter int PREAMBLE_MIN = 10
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    halfOne,
  input  logic    halfZero,
  input  logic    lastBit,
  input  logic    atMax,
  output dpCtrl_t ctrl,
  output logic    packetValid,
  output logic    frameError
);

  localparam int ONES_W = $clog2(PREAMBLE_MIN + 1);
  localparam logic [ONES_W-1:0] ONES_SAT = ONES_W'(PREAMBLE_MIN);

  halfState_t        halfState, nextHalf;
  frameState_t       frame, nextFrame;
  logic [ONES_W-1:0] onesCnt, nextOnes;
  logic              bitOk, bitVal, mismatch;
  logic              validNext, errNext;

  // Pair half-bits into bits
  always_comb begin
    nextHalf = halfState;
    bitOk    = 1'b0;
    bitVal   = 1'b0;
    mismatch = 1'b0;
    if (halfOne) begin
      case (halfState)
        HALF_ANY: nextHalf = HALF_ONE;
        HALF_ONE: begin bitOk = 1'b1; bitVal = 1'b1; nextHalf = HALF_ANY; end
        default:  begin mismatch = 1'b1; nextHalf = HALF_ANY; end
      endcase
    end else if (halfZero) begin
      case (halfState)
        HALF_ANY:  nextHalf = HALF_ZERO;
        HALF_ZERO: begin bitOk = 1'b1; nextHalf = HALF_ANY; end
        default:   begin mismatch = 1'b1; nextHalf = HALF_ANY; end
      endcase
    end
  end

  // Frame tracking
  always_comb begin
    nextFrame = frame;
    nextOnes  = onesCnt;
    validNext = 1'b0;
    errNext   = 1'b0;
    ctrl      = '0;
    ctrl.bitVal = bitVal;
    if (mismatch) begin
      nextFrame = FR_PREAMBLE;
      nextOnes  = '0;
      errNext   = 1'b1;
    end else if (bitOk) begin
      case (frame)
        FR_PREAMBLE: begin
          if (bitVal) begin
            if (onesCnt >= ONES_SAT) nextFrame = FR_START;
            else                     nextOnes  = onesCnt + 1'b1;
          end else begin
            nextOnes = '0;
          end
        end
        FR_START: begin
          if (!bitVal) begin
            ctrl.clearAll = 1'b1;
            nextFrame     = FR_DATA;
          end
        end
        FR_DATA: begin
          if (!lastBit) begin
            ctrl.shiftIn = 1'b1;
          end else if (atMax) begin
            errNext   = 1'b1;
            nextFrame = FR_PREAMBLE;
            nextOnes  = '0;
          end else begin
            ctrl.commitByte = 1'b1;
            nextFrame       = FR_SEP;
          end
        end
        default: begin
          if (bitVal) begin
            validNext = 1'b1;
            nextFrame = FR_PREAMBLE;
            nextOnes  = '0;
          end else begin
            nextFrame = FR_DATA;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halfState   <= HALF_ANY;
      frame       <= FR_PREAMBLE;
      onesCnt     <= '0;
      packetValid <= 1'b0;
      frameError  <= 1'b0;
    end else begin
      halfState   <= nextHalf;
      frame       <= nextFrame;
      onesCnt     <= nextOnes;
      packetValid <= validNext;
      frameError  <= errNext;
    end
  end

endmodule

// File: rtl/dcc_rx_top.sv
module dcc_rx_top
  import dcc_rx_pkg::*;
#(
  parameter int TIMER_W      = 16,
  parameter int ONE_MIN      = 52,
  parameter int ONE_MAX      = 64,
  parameter int ZERO_MIN     = 90,
  parameter int ZERO_MAX     = 10000,
  parameter int MAX_BYTES    = 6,
  parameter int PREAMBLE_MIN = 10,
  parameter int CNT_W        = $clog2(MAX_BYTES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic                   trackIn,
  output logic [MAX_BYTES*8-1:0] rxBytes,
  output logic [CNT_W-1:0]       byteCount,
  output logic                   packetValid,
  output logic                   frameError
);

  dpCtrl_t ctrl;
  logic    halfOne, halfZero, lastBit, atMax;

  dcc_rx_datapath #(
    .TIMER_W(TIMER_W), .ONE_MIN(ONE_MIN), .ONE_MAX(ONE_MAX),
    .ZERO_MIN(ZERO_MIN), .ZERO_MAX(ZERO_MAX),
    .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trackIn(trackIn), .ctrl(ctrl),
    .halfOne(halfOne), .halfZero(halfZero), .lastBit(lastBit), .atMax(atMax),
    .rxBytes(rxBytes), .byteCount(byteCount)
  );

  dcc_rx_control #(.PREAMBLE_MIN(PREAMBLE_MIN)) u_ctl (
    .clk(clk), .rst_n(rst_n), .halfOne(halfOne), .halfZero(halfZero),
    .lastBit(lastBit), .atMax(atMax), .ctrl(ctrl),
    .packetValid(packetValid), .frameError(frameError)
  );

endmodule

// File: rtl/dcc_rx_checker.sv
module dcc_rx_checker #(
  parameter int MAX_BYTES = 6,
  parameter int CNT_W     = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] byteCount,
  input logic             packetValid,
  input logic             frameError
);

  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(packetValid && frameError));

  p_valid_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    packetValid |=> !packetValid);

  p_error_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frameError |=> !frameError);

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byteCount <= CNT_W'(MAX_BYTES));

  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (byteCount != $past(byteCount)) |->
      ((byteCount == $past(byteCount) + CNT_W'(1)) || (byteCount == '0)));

  p_valid_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    packetValid |-> (byteCount != '0));

endmodule

bind dcc_rx_top dcc_rx_checker #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byteCount(byteCount),
  .packetValid(packetValid), .frameError(frameError)
);

// File: tb/tb_dcc_rx_top.sv
module tb_dcc_rx_top;

  localparam int MAX_BYTES = 6;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int NV        = 6;

  // Vector: [64:60] preamble ones, [59:56] byte count, byte i at [8i+7:8i]
  localparam logic [64:0] VEC [NV] = '{
    {5'd12, 4'd3, 32'h0, 8'hA5, 8'h3F, 8'h03},
    {5'd11, 4'd1, 48'h0, 8'hFF},
    {5'd10, 4'd2, 40'h0, 8'h0F, 8'h00},
    {5'd14, 4'd6, 8'h0, 48'hC3_7E_01_80_55_AA},
    {5'd12, 4'd7, 56'h11_22_33_44_55_66_77},
    {5'd16, 4'd2, 40'h0, 8'h01, 8'h80}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic trackIn = 1'b0;
  logic [MAX_BYTES*8-1:0] rxBytes;
  logic [CNT_W-1:0]       byteCount;
  logic packetValid, frameError;

  int errors = 0;
  int checks = 0;
  int validCnt = 0;
  int errCnt = 0;
  int oneW = 58;
  int zeroW = 95;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dcc_rx_top dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trackIn(trackIn),
    .rxBytes(rxBytes), .byteCount(byteCount),
    .packetValid(packetValid), .frameError(frameError)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (packetValid) validCnt++;
      if (frameError)  errCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendHalf(input int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
    trackIn = ~trackIn;
  endtask

  task automatic sendBit(input bit b);
    sendHalf(b ? oneW : zeroW);
    sendHalf(b ? oneW : zeroW);
  endtask

  task automatic sendPacket(input int pre, input int n, input logic [55:0] data);
    sendBit(1'b0);
    repeat (pre) sendBit(1'b1);
    sendBit(1'b0);
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) sendBit(data[8*i + b]);
      if (i < n - 1) sendBit(1'b0);
    end
    sendBit(1'b1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int v0, e0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(byteCount == 0, "R1 count in reset", byteCount, 0);
    check(rxBytes == '0, "R1 bytes in reset", rxBytes, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!packetValid && !frameError, "R1 pulses after reset", {packetValid, frameError}, 0);
    check(byteCount == 0, "R1 count after reset", byteCount, 0);

    // Vector table: R5, R6, R7, R8, R9
    for (int k = 0; k < NV; k++) begin
      int pre, n;
      bit expValid, expErr;
      pre = int'(VEC[k][64:60]);
      n   = int'(VEC[k][59:56]);
      expValid = (pre > 10) && (n <= MAX_BYTES);
      expErr   = (pre > 10) && (n > MAX_BYTES);
      v0 = validCnt; e0 = errCnt;
      sendPacket(pre, n, VEC[k][55:0]);
      check((validCnt - v0) == int'(expValid), "R5/R8 packetValid count", validCnt - v0, expValid);
      check((errCnt - e0) == int'(expErr), "R9 frameError count", errCnt - e0, expErr);
      if (expValid) begin
        check(byteCount == CNT_W'(n), "R8 final byteCount", byteCount, n);
        for (int i = 0; i < n; i++)
          check(rxBytes[8*i +: 8] == VEC[k][8*i +: 8], "R7 byte MSB first",
                rxBytes[8*i +: 8], VEC[k][8*i +: 8]);
      end
    end

    // R6: the start bit clears the previous packet's bytes
    sendPacket(12, 1, 56'h5A);
    check(byteCount == 1, "R6 count restarts", byteCount, 1);
    check(rxBytes[47:8] == '0, "R6 old bytes cleared", rxBytes[47:8], 0);

    // R4: mismatched halves abort, then recovery
    v0 = validCnt; e0 = errCnt;
    sendBit(1'b0);
    repeat (12) sendBit(1'b1);
    sendBit(1'b0);
    sendHalf(oneW);
    sendHalf(zeroW);
    repeat (4) @(negedge clk);
    check((errCnt - e0) == 1, "R4 mismatch raises frameError", errCnt - e0, 1);
    check(validCnt == v0, "R4 no packet after mismatch", validCnt - v0, 0);
    sendPacket(12, 1, 56'h96);
    check((validCnt - v0) == 1, "R4 recovery packet", validCnt - v0, 1);
    check(rxBytes[7:0] == 8'h96, "R4 recovery byte", rxBytes[7:0], 8'h96);

    // R5: preamble ones split by a zero are not enough
    v0 = validCnt;
    sendBit(1'b0);
    repeat (6) sendBit(1'b1);
    sendBit(1'b0);
    repeat (6) sendBit(1'b1);
    sendBit(1'b0);
    for (int b = 7; b >= 0; b--) sendBit(b[0]);
    sendBit(1'b1);
    repeat (4) @(negedge clk);
    check(validCnt == v0, "R5 split preamble rejected", validCnt - v0, 0);

    // R3: out-of-band intervals inserted between halves, byte C3
    v0 = validCnt; e0 = errCnt;
    sendBit(1'b0);
    repeat (12) sendBit(1'b1);
    sendBit(1'b0);
    sendHalf(oneW); sendHalf(75); sendHalf(oneW);        // 1
    sendBit(1'b1);                                        // 1
    sendHalf(zeroW); sendHalf(12000); sendHalf(zeroW);    // 0
    sendHalf(30); sendHalf(zeroW); sendHalf(zeroW);       // 0
    sendBit(1'b0); sendBit(1'b0);
    sendBit(1'b1); sendBit(1'b1);
    sendBit(1'b1);
    repeat (4) @(negedge clk);
    check((validCnt - v0) == 1, "R3 packet survives noise", validCnt - v0, 1);
    check(errCnt == e0, "R3 no error from noise", errCnt - e0, 0);
    check(rxBytes[7:0] == 8'hC3, "R3 byte intact", rxBytes[7:0], 8'hC3);

    // R2: window boundaries
    oneW = 52; zeroW = 90;
    v0 = validCnt;
    sendPacket(12, 1, 56'h6C);
    check((validCnt - v0) == 1, "R2 low edges accepted", validCnt - v0, 1);
    check(rxBytes[7:0] == 8'h6C, "R2 low edges byte", rxBytes[7:0], 8'h6C);
    oneW = 64;
    v0 = validCnt;
    sendPacket(12, 1, 56'h39);
    check((validCnt - v0) == 1, "R2 one upper edge accepted", validCnt - v0, 1);
    oneW = 65;
    v0 = validCnt; e0 = errCnt;
    sendPacket(12, 1, 56'hF0);
    check(validCnt == v0, "R2 one-half at 65 ignored", validCnt - v0, 0);
    check(byteCount == 1 && rxBytes[7:0] == 8'h39, "R2 state untouched by 65",
          rxBytes[7:0], 8'h39);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule